// File: doc/BRIEF.md
# Serial Strobed Register Slave

This block is a small board-controller register bank that a host reaches over three serial wires (clock, data in, data out) plus a separate active-low strobe line. There is no chip select. The shifter is always listening, and ordinary clock pulses happen only while the strobe is high. A command is committed by a single serial clock pulse given while the strobe is low. The level of the data-in line during that pulse chooses a write (high) or a read (low).

A write shifts a 32-bit data word followed by an 8-bit address, then commits with a write strobe. A read shifts only the 8-bit address and commits with a read strobe. The addressed word is then clocked out on the data-out line as 32 bits. The bank holds five 32-bit words:
- a mode word and a mux word, both writable, which also drive output pins;
- a reset-control word, whose value 1 raises a one-cycle system reset request;
- a switch word taken from input pins (read-only);
- a fixed version word (read-only).

All serial inputs are oversampled in a faster system clock, which must run at least four times the serial clock rate. The link carries no valid/ready handshake and offers no back-pressure. The host paces every bit itself, and the block keeps up with any serial clock inside that ratio. Data words are kept and returned exactly in wire order; any byte reordering is left to the host.

Top module: `ssr_slave`

## Requirements
- R1: After reset, mode_o, mux_o and the reset-control word are 0, miso_o is 0 and sys_rst_req_o is 0.
- R2: Address 0x00 holds the mode word and address 0x02 holds the mux word. Both can be written and read back, and mode_o and mux_o always show the stored values.
- R3: Bits are sampled on the SCLK rising edge while the strobe is high, most significant bit first. At a write strobe, the last 8 bits shifted are the address and the 32 bits before them are the data; any earlier bits are dropped. The word is stored with no byte reordering.
- R4: Shifting alone never changes a register. Only an SCLK pulse while strobe_n_i is low commits: MOSI=1 at that pulse writes, and MOSI=0 reads.
- R5: A read strobe loads the word at the last 8 shifted address bits. Its bit 31 appears on miso_o before the next SCLK rising edge. Each SCLK falling edge while the strobe is high advances one bit, MSB first.
- R6: Address 0x08 returns sw_i and address 0xFF returns the VERSION_WORD parameter. Writes to either address leave every register unchanged.
- R7: Reads from an unmapped address return 0, and writes to an unmapped address leave every register unchanged.
- R8: Writing exactly 1 to address 0x80 gives exactly one system-clock cycle of sys_rst_req_o, after which the word reads back 0. Any other value is stored, reads back unchanged and gives no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| strobe_n_i | input | 1 | Active-low command strobe |
| mosi_i | input | 1 | Serial data in; command level during strobe |
| sw_i | input | 32 | Switch word, read-only at 0x08 |
| miso_o | output | 1 | Serial data out |
| mode_o | output | 32 | Stored mode word |
| mux_o | output | 32 | Stored mux word |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench goes after the corner cases where a slipped frame would be invisible in a plain write/readback:
- A write preceded by extra bits. A design that counted bits from some start instead of keeping the latest 40 would take the wrong address.
- A read strobe given after a full data frame. A design that treated every strobe as a write would corrupt the mode word.
- Read-only, unmapped and reset-control writes. A design that decoded addresses loosely would overwrite mode or mux, or raise a reset for a value other than 1. Counting request cycles catches a pulse that is stretched or missing.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int ADDR_W  = 8;
  localparam int WORD_W  = 32;
  localparam int CHAIN_W = WORD_W + ADDR_W;

  localparam logic [ADDR_W-1:0] A_MODE    = 8'h00;
  localparam logic [ADDR_W-1:0] A_MUX     = 8'h02;
  localparam logic [ADDR_W-1:0] A_SWITCH  = 8'h08;
  localparam logic [ADDR_W-1:0] A_RSTCTL  = 8'h80;
  localparam logic [ADDR_W-1:0] A_VERSION = 8'hFF;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int           W      = 1,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= INIT;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
  import ssr_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              strobe_n_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              miso_o
);
  localparam int LINK_W = DATA_W + ADDR_W;

  logic              sclk_d;
  logic              sclk_rise, sclk_fall;
  logic [LINK_W-1:0] link_q;
  logic [DATA_W-1:0] out_q;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      link_q  <= '0;
      wr_en_o <= 1'b0;
      rd_en_o <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      wr_en_o <= 1'b0;
      rd_en_o <= 1'b0;
      if (sclk_rise) begin
        if (strobe_n_s) link_q <= {link_q[LINK_W-2:0], mosi_s};
        else begin
          wr_en_o <= mosi_s;
          rd_en_o <= ~mosi_s;
        end
      end
    end
  end

  assign addr_o    = link_q[ADDR_W-1:0];
  assign wr_data_o = link_q[LINK_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       out_q <= '0;
    else if (rd_en_o)                 out_q <= rd_data_i;
    else if (sclk_fall && strobe_n_s) out_q <= {out_q[DATA_W-2:0], 1'b0};
  end

  assign miso_o = out_q[DATA_W-1];

  // R4: a command can only be issued from a strobe-low clock pulse
  assert_cmd_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o || rd_en_o) |-> $past(!strobe_n_s));
  assert_cmd_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en_o, rd_en_o}));
  // R5: the serial output only moves on a load or a strobe-high falling edge
  assert_miso_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_o && !(sclk_fall && strobe_n_s)) |=> $stable(miso_o));
endmodule

// File: rtl/ssr_regbank.sv
module ssr_regbank
  import ssr_pkg::*;
#(
  parameter int                DATA_W       = WORD_W,
  parameter logic [DATA_W-1:0] VERSION_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mux_o,
  output logic              rst_req_o
);
  localparam logic [DATA_W-1:0] RST_KEY = DATA_W'(1);

  logic [DATA_W-1:0] mode_q, mux_q, rstctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      mux_q     <= '0;
      rstctl_q  <= '0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= 1'b0;
      if (rstctl_q == RST_KEY) begin
        rst_req_o <= 1'b1;
        rstctl_q  <= '0;
      end
      if (wr_en_i) begin
        case (addr_i)
          A_MODE:   mode_q   <= wr_data_i;
          A_MUX:    mux_q    <= wr_data_i;
          A_RSTCTL: rstctl_q <= wr_data_i;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_MODE:    rd_data_o = mode_q;
      A_MUX:     rd_data_o = mux_q;
      A_SWITCH:  rd_data_o = sw_i;
      A_RSTCTL:  rd_data_o = rstctl_q;
      A_VERSION: rd_data_o = VERSION_WORD;
      default:   rd_data_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign mux_o  = mux_q;

  // R8: the reset request never lasts more than one cycle
  assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  // R6 / R7: writes elsewhere leave mode and mux alone
  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i != A_MODE) |=> $stable(mode_q));
  assert_mux_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i != A_MUX) |=> $stable(mux_q));
  // R4: without a commit nothing in the bank changes
  assert_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(mode_q) && $stable(mux_q)));
endmodule

// File: rtl/ssr_slave.sv
module ssr_slave
  import ssr_pkg::*;
#(
  parameter int                DATA_W       = WORD_W,
  parameter int                SYNC_STAGES  = 2,
  parameter logic [DATA_W-1:0] VERSION_WORD = 32'h0002_0117
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              strobe_n_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic              miso_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mux_o,
  output logic              sys_rst_req_o
);
  logic [2:0]        pins_s;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  ssr_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sclk_i, strobe_n_i, mosi_i}),
    .q_o   (pins_s)
  );

  ssr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s     (pins_s[2]),
    .strobe_n_s (pins_s[1]),
    .mosi_s     (pins_s[0]),
    .rd_data_i  (rd_data),
    .wr_en_o    (wr_en),
    .rd_en_o    (rd_en),
    .addr_o     (addr),
    .wr_data_o  (wr_data),
    .miso_o     (miso_o)
  );

  ssr_regbank #(.DATA_W(DATA_W), .VERSION_WORD(VERSION_WORD)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wr_data),
    .sw_i      (sw_i),
    .rd_data_o (rd_data),
    .mode_o    (mode_o),
    .mux_o     (mux_o),
    .rst_req_o (sys_rst_req_o)
  );

  // R1: outputs quiet straight after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sys_rst_req_o && mode_o == '0 && mux_o == '0));
endmodule

// File: tb/ssr_slave_tb.sv
module ssr_slave_tb;
  localparam int          HP   = 6;
  localparam logic [31:0] SW   = 32'hA5C3_0F81;
  localparam logic [31:0] VER  = 32'h0002_0117;

  logic clk = 0, rst_n = 0, sclk = 0, strb_n = 1, mosi = 0;
  logic miso, rst_req;
  logic [31:0] mode, mux;
  int checks = 0, fails = 0, rst_pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ssr_slave #(.VERSION_WORD(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .strobe_n_i(strb_n), .mosi_i(mosi),
    .sw_i(SW), .miso_o(miso), .mode_o(mode), .mux_o(mux), .sys_rst_req_o(rst_req));

  always @(negedge clk) if (rst_req) rst_pulses++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic gap(int n); repeat (n) @(negedge clk); endtask

  task automatic put_bit(logic b);
    mosi = b; gap(HP); sclk = 1; gap(HP); sclk = 0;
  endtask

  task automatic shift(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic strobe(logic cmd);
    mosi = cmd; gap(HP); strb_n = 0; gap(HP); sclk = 1; gap(HP);
    sclk = 0; gap(HP); strb_n = 1; gap(HP);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    shift({24'h0, d, a}, 40); strobe(1'b1); gap(4);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    shift({56'h0, a}, 8); strobe(1'b0);
    for (int i = 31; i >= 0; i--) begin
      d[i] = miso; sclk = 1; gap(HP); sclk = 0; gap(HP);
    end
  endtask

  task automatic t_reset;
    chk("R1 mode", mode, 0); chk("R1 mux", mux, 0);
    chk("R1 miso", {31'h0, miso}, 0); chk("R1 rst_req", {31'h0, rst_req}, 0);
  endtask

  task automatic t_rw;
    logic [31:0] d;
    wr(8'h00, 32'h1234_5678); chk("R2 mode_o", mode, 32'h1234_5678);
    rd(8'h00, d); chk("R2 R5 mode readback", d, 32'h1234_5678);
    wr(8'h02, 32'h8000_0001); chk("R2 mux_o", mux, 32'h8000_0001);
    rd(8'h02, d); chk("R2 R3 mux readback", d, 32'h8000_0001);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    rd(8'h08, d); chk("R6 switch", d, SW);
    rd(8'hFF, d); chk("R6 version", d, VER);
    wr(8'h08, 32'hDEAD_BEEF); rd(8'h08, d); chk("R6 switch after write", d, SW);
    wr(8'hFF, 32'hDEAD_BEEF); rd(8'hFF, d); chk("R6 version after write", d, VER);
    chk("R6 mode untouched", mode, 32'h1234_5678);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'h01, d); chk("R7 unmapped read", d, 0);
    wr(8'h01, 32'hFFFF_FFFF);
    chk("R7 mode kept", mode, 32'h1234_5678); chk("R7 mux kept", mux, 32'h8000_0001);
    rd(8'h40, d); chk("R7 unmapped read 0x40", d, 0);
  endtask

  task automatic t_frame;
    shift({24'h0, 32'hCAFE_F00D, 8'h00}, 40);
    chk("R4 shift alone no change", mode, 32'h1234_5678);
    strobe(1'b0); gap(4);
    chk("R4 read strobe does not write", mode, 32'h1234_5678);
    shift(64'hFFFF, 16); wr(8'h00, 32'h0F0F_A5A5);
    chk("R3 last 40 bits win", mode, 32'h0F0F_A5A5);
  endtask

  task automatic t_reset_ctl;
    logic [31:0] d;
    int p0;
    p0 = rst_pulses; wr(8'h80, 32'h0000_0002); gap(8);
    chk("R8 no pulse for 2", rst_pulses - p0, 0);
    rd(8'h80, d); chk("R8 stored value 2", d, 2);
    p0 = rst_pulses; wr(8'h80, 32'h0000_0001); gap(8);
    chk("R8 one pulse for 1", rst_pulses - p0, 1);
    rd(8'h80, d); chk("R8 self clear", d, 0);
    chk("R8 mode kept", mode, 32'h0F0F_A5A5);
  endtask

  initial begin
    gap(5); rst_n = 1; gap(5);
    t_reset; t_rw; t_readonly; t_unmapped; t_frame; t_reset_ctl;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule